// File: doc/BRIEF.md
# Four-Wide Group Register Renamer

This block takes a group of up to four instructions each cycle and replaces their architectural register names with physical register names. Each instruction has two source operands and an optional destination. Sources with no earlier writer in the group read the map table. A source whose register is written by an earlier instruction of the same group takes the physical register just given to the youngest such writer. Every destination other than register zero gets a fresh physical register from a circular free list. The block reports the physical register that held the previous value of that destination, so the commit logic can free it once the instruction retires.

The physical pool has 96 registers covering 32 architectural ones, which leaves 64 free after reset. Because a register stays allocated until commit, this pool bounds how many instructions can be in flight. Commit returns up to four registers per cycle through the free lanes. When the group needs more registers than are free, the block raises a combinational stall and renames nothing from that group. The renamed group appears on the registered outputs one cycle after it is accepted.

Top module: `group_renamer`

## Requirements
- R1: A group offered with inValid high and stall low is accepted, and its renamed fields appear with outValid high on the next cycle. In any other cycle outValid is low on the following cycle.
- R2: After reset the map table is the identity: architectural register i maps to physical register i. A source with no earlier in-group writer takes the current map table entry.
- R3: A source whose architectural register is written by an earlier lane of the same group takes the new physical register of the nearest such earlier lane. Lane 0 is oldest and lane 3 is youngest. A lane's own destination never feeds its own sources.
- R4: When several lanes write the same architectural register, the map table keeps the new register of the youngest of them. A later group reading that register sees that value.
- R5: outOld for a renamed destination is the mapping that the destination had just before this lane: the new register of an earlier in-group writer, or else the map table entry.
- R6: Architectural register 0 is never renamed. A source naming it yields physical 0. A destination naming it allocates nothing and gives outDstEn low.
- R7: A lane with inDstEn low allocates nothing and gives outDstEn low. The following allocating lanes take the next free registers without a gap.
- R8: The free list is first-in first-out. After reset it holds physical registers 32 to 95 in rising order, and allocating lanes take them in lane order.
- R9: stall is high in the same cycle when inValid is high and fewer registers are free than the group has allocating lanes. A stalled group changes neither the map table nor the free list.
- R10: Up to four freed registers per cycle, given by freeValid and freePhys, are appended in lane order behind the registers already free. They count toward availability only from the next cycle.
- R11: All new physical registers handed out within one group are distinct and non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A group is offered this cycle |
| inSrcA | input | 4x5 | First source architectural register per lane |
| inSrcB | input | 4x5 | Second source architectural register per lane |
| inDst | input | 4x5 | Destination architectural register per lane |
| inDstEn | input | 4 | Lane has a destination |
| stall | output | 1 | Group rejected for lack of free registers |
| freeValid | input | 4 | Commit free lane active |
| freePhys | input | 4x7 | Physical register returned by each free lane |
| outValid | output | 1 | Renamed group present |
| outSrcA | output | 4x7 | Renamed first source per lane |
| outSrcB | output | 4x7 | Renamed second source per lane |
| outDst | output | 4x7 | New physical destination per lane |
| outOld | output | 4x7 | Previous physical mapping of the destination per lane |
| outDstEn | output | 4 | Lane allocated a new register |

## Verification
The assertions check on every cycle that an accepted group produces output one cycle later, and that a stalled or idle cycle produces none. They also check that new registers within a group are distinct and non-zero, and that the free count never exceeds the free pool size. Correct bypass between lanes, the youngest-writer rule for the map table, the old-mapping values and the FIFO reuse order can only be shown by the bench. It replays directed and random groups against a one-instruction-at-a-time rename model and compares every renamed field.

// File: rtl/group_renamer_pkg.sv
package group_renamer_pkg;
  localparam int WIDTH     = 4;
  localparam int ARCH_REGS = 32;
  localparam int PHYS_REGS = 96;
  localparam int AW        = $clog2(ARCH_REGS);
  localparam int PW        = $clog2(PHYS_REGS);
  localparam int FL_DEPTH  = PHYS_REGS;
  localparam int FL_INIT   = PHYS_REGS - ARCH_REGS;
  localparam int CW        = $clog2(FL_DEPTH + 1);
  localparam int OW        = $clog2(WIDTH + 1);

  typedef struct packed {
    logic          accept;
    logic [PW-1:0] popBase;
    logic [PW-1:0] pushBase;
  } ctrlStrobes_t;

  function automatic logic [PW-1:0] wrapAdd(logic [PW-1:0] base, logic [OW-1:0] off);
    logic [PW:0] sum;
    sum = {1'b0, base} + (PW+1)'(off);
    if (sum >= (PW+1)'(FL_DEPTH)) sum = sum - (PW+1)'(FL_DEPTH);
    return sum[PW-1:0];
  endfunction
endpackage

// File: rtl/group_renamer_ctrl.sv
module group_renamer_ctrl
  import group_renamer_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   needMask,
  input  logic [WIDTH-1:0]   freeValid,
  output logic               stall,
  output logic [CW-1:0]      freeCount,
  output ctrlStrobes_t       strobes
);
  logic [PW-1:0] headPtr;
  logic [PW-1:0] tailPtr;
  logic [OW-1:0] needCount;
  logic [OW-1:0] pushCount;
  logic          accept;

  always_comb begin
    needCount = '0;
    pushCount = '0;
    for (int i = 0; i < WIDTH; i++) begin
      needCount = needCount + OW'(needMask[i]);
      pushCount = pushCount + OW'(freeValid[i]);
    end
  end

  assign stall  = inValid && (freeCount < CW'(needCount));
  assign accept = inValid && !stall;

  assign strobes.accept   = accept;
  assign strobes.popBase  = headPtr;
  assign strobes.pushBase = tailPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= PW'(FL_INIT % FL_DEPTH);
      freeCount <= CW'(FL_INIT);
    end else begin
      if (accept) headPtr <= wrapAdd(headPtr, needCount);
      tailPtr   <= wrapAdd(tailPtr, pushCount);
      freeCount <= freeCount + CW'(pushCount) - (accept ? CW'(needCount) : CW'(0));
    end
  end
endmodule

// File: rtl/group_renamer_dpath.sv
module group_renamer_dpath
  import group_renamer_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic [WIDTH-1:0][AW-1:0]   inSrcA,
  input  logic [WIDTH-1:0][AW-1:0]   inSrcB,
  input  logic [WIDTH-1:0][AW-1:0]   inDst,
  input  logic [WIDTH-1:0]           inDstEn,
  input  logic [WIDTH-1:0]           freeValid,
  input  logic [WIDTH-1:0][PW-1:0]   freePhys,
  output logic [WIDTH-1:0]           needMask,
  output logic                       outValid,
  output logic [WIDTH-1:0][PW-1:0]   outSrcA,
  output logic [WIDTH-1:0][PW-1:0]   outSrcB,
  output logic [WIDTH-1:0][PW-1:0]   outDst,
  output logic [WIDTH-1:0][PW-1:0]   outOld,
  output logic [WIDTH-1:0]           outDstEn
);
  logic [PW-1:0] mapTable [ARCH_REGS];
  logic [PW-1:0] freeMem  [FL_DEPTH];

  logic [WIDTH-1:0][OW-1:0] allocOff;
  logic [WIDTH-1:0][OW-1:0] pushOff;
  logic [WIDTH-1:0][PW-1:0] newPhys;
  logic [WIDTH-1:0][PW-1:0] resA;
  logic [WIDTH-1:0][PW-1:0] resB;
  logic [WIDTH-1:0][PW-1:0] resOld;

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      needMask[i] = inDstEn[i] && (inDst[i] != '0);
  end

  always_comb begin
    logic [OW-1:0] a;
    logic [OW-1:0] p;
    a = '0;
    p = '0;
    for (int i = 0; i < WIDTH; i++) begin
      allocOff[i] = a;
      pushOff[i]  = p;
      a = a + OW'(needMask[i]);
      p = p + OW'(freeValid[i]);
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign newPhys[i] = freeMem[wrapAdd(strobes.popBase, allocOff[i])];

    always_comb begin
      resA[i]   = mapTable[inSrcA[i]];
      resB[i]   = mapTable[inSrcB[i]];
      resOld[i] = mapTable[inDst[i]];
      for (int j = 0; j < i; j++) begin
        if (needMask[j] && inDst[j] == inSrcA[i]) resA[i]   = newPhys[j];
        if (needMask[j] && inDst[j] == inSrcB[i]) resB[i]   = newPhys[j];
        if (needMask[j] && inDst[j] == inDst[i])  resOld[i] = newPhys[j];
      end
      if (inSrcA[i] == '0) resA[i] = '0;
      if (inSrcB[i] == '0) resB[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ARCH_REGS; r++) mapTable[r] <= PW'(r);
    end else if (strobes.accept) begin
      for (int i = 0; i < WIDTH; i++)
        if (needMask[i]) mapTable[inDst[i]] <= newPhys[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < FL_DEPTH; k++)
        freeMem[k] <= (k < FL_INIT) ? PW'(k + ARCH_REGS) : '0;
    end else begin
      for (int i = 0; i < WIDTH; i++)
        if (freeValid[i]) freeMem[wrapAdd(strobes.pushBase, pushOff[i])] <= freePhys[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSrcA  <= '0;
      outSrcB  <= '0;
      outDst   <= '0;
      outOld   <= '0;
      outDstEn <= '0;
    end else begin
      outValid <= strobes.accept;
      if (strobes.accept) begin
        outSrcA  <= resA;
        outSrcB  <= resB;
        outDst   <= newPhys;
        outOld   <= resOld;
        outDstEn <= needMask;
      end
    end
  end
endmodule

// File: rtl/group_renamer.sv
module group_renamer
  import group_renamer_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [WIDTH-1:0][AW-1:0]   inSrcA,
  input  logic [WIDTH-1:0][AW-1:0]   inSrcB,
  input  logic [WIDTH-1:0][AW-1:0]   inDst,
  input  logic [WIDTH-1:0]           inDstEn,
  output logic                       stall,
  input  logic [WIDTH-1:0]           freeValid,
  input  logic [WIDTH-1:0][PW-1:0]   freePhys,
  output logic                       outValid,
  output logic [WIDTH-1:0][PW-1:0]   outSrcA,
  output logic [WIDTH-1:0][PW-1:0]   outSrcB,
  output logic [WIDTH-1:0][PW-1:0]   outDst,
  output logic [WIDTH-1:0][PW-1:0]   outOld,
  output logic [WIDTH-1:0]           outDstEn
);
  ctrlStrobes_t       strobes;
  logic [WIDTH-1:0]   needMask;
  logic [CW-1:0]      freeCount;

  group_renamer_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .needMask(needMask),
    .freeValid(freeValid), .stall(stall), .freeCount(freeCount), .strobes(strobes)
  );

  group_renamer_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst), .inDstEn(inDstEn),
    .freeValid(freeValid), .freePhys(freePhys), .needMask(needMask),
    .outValid(outValid), .outSrcA(outSrcA), .outSrcB(outSrcB),
    .outDst(outDst), .outOld(outOld), .outDstEn(outDstEn)
  );
endmodule

// File: rtl/group_renamer_chk.sv
module group_renamer_chk
  import group_renamer_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     stall,
  input logic                     outValid,
  input logic [WIDTH-1:0]         outDstEn,
  input logic [WIDTH-1:0][PW-1:0] outDst,
  input logic [CW-1:0]            freeCount
);
  AST_ACCEPT_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !stall) |=> outValid); // R1
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R1
  AST_STALL_NO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && stall) |=> !outValid); // R9
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freeCount <= CW'(FL_INIT)); // R10

  for (genvar i = 0; i < WIDTH; i++) begin : g_nz
    AST_NEW_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && outDstEn[i]) |-> (outDst[i] != '0)); // R11
    for (genvar j = i + 1; j < WIDTH; j++) begin : g_pair
      AST_NEW_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && outDstEn[i] && outDstEn[j]) |-> (outDst[i] != outDst[j])); // R11
    end
  end
endmodule

bind group_renamer group_renamer_chk chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .stall(stall), .outValid(outValid),
  .outDstEn(outDstEn), .outDst(outDst), .freeCount(freeCount)
);

// File: tb/group_renamer_tb_top.sv
`timescale 1ns/100ps
module group_renamer_tb_top;
  import group_renamer_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [WIDTH-1:0][AW-1:0] inSrcA = '0, inSrcB = '0, inDst = '0;
  logic [WIDTH-1:0] inDstEn = '0;
  logic stall;
  logic [WIDTH-1:0] freeValid = '0;
  logic [WIDTH-1:0][PW-1:0] freePhys = '0;
  logic outValid;
  logic [WIDTH-1:0][PW-1:0] outSrcA, outSrcB, outDst, outOld;
  logic [WIDTH-1:0] outDstEn;

  always #2 clk = ~clk;

  group_renamer dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .inDst(inDst), .inDstEn(inDstEn), .stall(stall), .freeValid(freeValid),
    .freePhys(freePhys), .outValid(outValid), .outSrcA(outSrcA), .outSrcB(outSrcB),
    .outDst(outDst), .outOld(outOld), .outDstEn(outDstEn)
  );

  typedef struct {
    bit v;
    int sa[WIDTH];
    int sb[WIDTH];
    int nd[WIDTH];
    int od[WIDTH];
    bit de[WIDTH];
  } exp_t;

  int checks = 0;
  int failures = 0;
  int stallsSeen = 0;
  int modelMap[ARCH_REGS];
  int freeQ[$];
  int pendQ[$];
  exp_t expQ[$];
  int stA[WIDTH], stB[WIDTH], stD[WIDTH];
  bit stE[WIDTH];
  bit monOn = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input int nFree);
    exp_t e;
    int need;
    int nf;
    int frees[$];
    bit expStall;
    @(negedge clk);
    inValid = v;
    need = 0;
    for (int i = 0; i < WIDTH; i++) begin
      inSrcA[i] = AW'(stA[i]);
      inSrcB[i] = AW'(stB[i]);
      inDst[i] = AW'(stD[i]);
      inDstEn[i] = stE[i];
      if (stE[i] && stD[i] != 0) need++;
    end
    nf = (nFree < pendQ.size()) ? nFree : pendQ.size();
    if (nf > WIDTH) nf = WIDTH;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < nf) begin
        int p;
        p = pendQ.pop_front();
        frees.push_back(p);
        freeValid[i] = 1'b1;
        freePhys[i] = PW'(p);
      end else begin
        freeValid[i] = 1'b0;
        freePhys[i] = '0;
      end
    end
    #0.5;
    expStall = v && (freeQ.size() < need);
    check(stall == expStall, "R9 stall", int'(stall), int'(expStall));
    if (expStall) stallsSeen++;
    e.v = v && !expStall;
    for (int i = 0; i < WIDTH; i++) begin
      e.sa[i] = 0; e.sb[i] = 0; e.nd[i] = 0; e.od[i] = 0; e.de[i] = 0;
    end
    if (e.v) begin
      for (int i = 0; i < WIDTH; i++) begin
        e.sa[i] = (stA[i] == 0) ? 0 : modelMap[stA[i]];
        e.sb[i] = (stB[i] == 0) ? 0 : modelMap[stB[i]];
        if (stE[i] && stD[i] != 0) begin
          e.de[i] = 1;
          e.nd[i] = freeQ.pop_front();
          e.od[i] = modelMap[stD[i]];
          modelMap[stD[i]] = e.nd[i];
          pendQ.push_back(e.od[i]);
        end
      end
    end
    foreach (frees[k]) freeQ.push_back(frees[k]);
    expQ.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (monOn && expQ.size() >= 2) begin
        exp_t e;
        e = expQ.pop_front();
        check(outValid == e.v, "R1 outValid", int'(outValid), int'(e.v));
        if (e.v && outValid) begin
          for (int i = 0; i < WIDTH; i++) begin
            check(int'(outSrcA[i]) == e.sa[i], "R2/R3 srcA", int'(outSrcA[i]), e.sa[i]);
            check(int'(outSrcB[i]) == e.sb[i], "R2/R3 srcB", int'(outSrcB[i]), e.sb[i]);
            check(outDstEn[i] == e.de[i], "R6/R7 dstEn", int'(outDstEn[i]), int'(e.de[i]));
            if (e.de[i]) begin
              check(int'(outDst[i]) == e.nd[i], "R8/R10 newDst", int'(outDst[i]), e.nd[i]);
              check(int'(outOld[i]) == e.od[i], "R4/R5 oldDst", int'(outOld[i]), e.od[i]);
            end
          end
        end
      end
    end
  end

  task automatic setLane(input int i, input int a, input int b, input int d, input bit en);
    stA[i] = a; stB[i] = b; stD[i] = d; stE[i] = en;
  endtask

  task automatic randGroup(input int span);
    for (int i = 0; i < WIDTH; i++)
      setLane(i, $urandom_range(span, 0), $urandom_range(span, 0),
              $urandom_range(span, 0), ($urandom_range(3, 0) != 0));
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    for (int r = 0; r < ARCH_REGS; r++) modelMap[r] = r;
    for (int k = ARCH_REGS; k < PHYS_REGS; k++) freeQ.push_back(k);
    for (int i = 0; i < WIDTH; i++) setLane(i, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1: reset state, nothing valid out, no stall while idle
    check(outValid == 1'b0, "R1 reset outValid", int'(outValid), 0);
    check(stall == 1'b0, "R9 reset stall", int'(stall), 0);
    monOn = 1'b1;

    // R8 and R2: first allocations are 32..35, sources read identity map
    setLane(0, 5, 6, 1, 1); setLane(1, 7, 8, 2, 1);
    setLane(2, 9, 10, 3, 1); setLane(3, 11, 12, 4, 1);
    step(1, 0);
    step(0, 0);
    check(int'(outDst[0]) == 32 && int'(outDst[3]) == 35, "R8 first allocation",
          int'(outDst[0]), 32);

    // R3 and R4: same register renamed by all four lanes, chained reads
    setLane(0, 5, 5, 5, 1); setLane(1, 5, 0, 5, 1);
    setLane(2, 5, 1, 5, 1); setLane(3, 5, 5, 5, 1);
    step(1, 0);
    setLane(0, 5, 5, 0, 0); setLane(1, 0, 0, 0, 0);
    setLane(2, 0, 0, 0, 0); setLane(3, 0, 0, 0, 0);
    step(1, 0);
    step(0, 0);
    check(int'(outSrcA[0]) == 39, "R4 youngest mapping kept", int'(outSrcA[0]), 39);

    // R6 and R7: destination zero and disabled destinations allocate nothing
    setLane(0, 0, 3, 0, 1); setLane(1, 2, 0, 9, 0);
    setLane(2, 0, 0, 9, 1); setLane(3, 9, 0, 0, 1);
    step(1, 0);
    step(0, 0);
    check(int'(outDst[2]) == 40, "R7 no gap in allocation", int'(outDst[2]), 40);
    check(outDstEn == 4'b0100, "R6 dest zero not renamed", int'(outDstEn), 4);

    // R9: exhaust the free list with no commits
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < WIDTH; i++) setLane(i, $urandom_range(31, 0), 0, $urandom_range(31, 1), 1);
      step(1, 0);
    end
    check(stallsSeen > 0, "R9 stall reached", stallsSeen, 1);

    // R10: commit frees reopen the free list, random dependent groups
    for (int n = 0; n < 600; n++) begin
      randGroup((n % 3 == 0) ? 31 : 7);
      step($urandom_range(4, 0) != 0, $urandom_range(4, 0));
    end
    for (int n = 0; n < 30; n++) begin
      for (int i = 0; i < WIDTH; i++) setLane(i, 0, 0, 0, 0);
      step(0, 4);
    end
    for (int i = 0; i < WIDTH; i++) setLane(i, 1, 2, 3, 1);
    step(1, 0);
    step(0, 0);
    step(0, 0);
    check(freeQ.size() + pendQ.size() == FL_INIT, "R10 pool conserved",
          freeQ.size() + pendQ.size(), FL_INIT);
    finish();
  end
endmodule